// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the device side of a two-wire serial memory. It watches an already-synchronised clock line and data line, and it answers by pulling the data line low through an open-drain enable. Behind the bus sits a 512-byte store, split into two 256-byte halves. A bit in the control byte picks the half, and a word-address byte picks the location inside it. The store is a plain register array that can map onto block RAM. The block keeps no real non-volatile storage.

Writes collect up to one page of bytes in a small buffer. When the bus master sends a stop, a self-timed commit copies the buffer into the store. The commit lasts a set number of clock cycles, and during that time the control byte is refused, so the master can poll for completion. Reads come from a single address pointer that survives between transactions. This pointer serves current-address reads, random reads (a write carrying only an address, then a repeated start) and acknowledged sequential streams. A write-protect input makes every write harmless and leaves reads unchanged.

Top module: `serial_eeprom_target`

## Requirements
- R1: A control byte is accepted (acknowledged) only when its top nibble is 4'b1010 and no commit is running. Bits 3:2 are ignored. Bit 1 selects the 256-byte half and bit 0 is the direction (1 = read). Any other control byte gets no acknowledge, and the block drives nothing until the next start or stop.
- R2: The block changes `sda_oe` only while SCL is low. A start is SDA falling while SCL stays high, and a stop is SDA rising while SCL stays high.
- R3: In a write, the block acknowledges the word-address byte. The pointer becomes {half-select bit, word address}, which is 9 bits wide (0x000 to 0x1FF).
- R4: Each acknowledged write data byte goes to page-buffer slot pointer[3:0], and then only pointer[3:0] increments, wrapping inside the 16-byte page. A 17th or later byte overwrites an earlier slot. The store changes only during the commit that follows a stop.
- R5: A repeated start after a write discards any buffered data and starts no commit. The pointer keeps the value that the write left, which gives the random read.
- R6: A read returns the byte at the pointer, and the pointer then holds that address plus one. After a write, it holds the last written address plus one within the page.
- R7: After a read byte, an acknowledge from the master sends the next byte. The pointer wraps from 0x1FF to 0x000. A non-acknowledge releases the line until the next start or stop.
- R8: A stop that ends a write with at least one data byte starts a commit that lasts WRITE_CYCLES clock cycles. Control bytes are not acknowledged during the commit.
- R9: While `wp_i` is high at the stop, the write is still acknowledged byte by byte. However, nothing is committed and no commit time is spent.
- R10: After reset, `sda_oe` is 0, the pointer is 0x000 and no commit is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line (resolved bus level) |
| wp_i | input | 1 | Write protect, high blocks all stores |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The bench keeps the default 9-bit address and 16-byte page, so a sequential read can cross the 0x1FF to 0x000 boundary and a page write can wrap and overwrite buffer slots. It sets WRITE_CYCLES to 200. That is long enough that a control byte sent right after a stop arrives inside the commit and is refused. It is also short enough that a later poll is acknowledged after a brief wait. The SCL half period of four clocks leaves room to check, on every clock, that the block drives the line only in the slots where the model expects it to.

// File: rtl/seep_pkg.sv
package seep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_READ,
    ST_SKIP
  } bus_st_t;

  localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/seep_bus_cond.sv
module seep_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise = ~scl_q & scl_i;
    scl_fall = scl_q & ~scl_i;
    start_c  = scl_q & scl_i & sda_q & ~sda_i;
    stop_c   = scl_q & scl_i & ~sda_q & sda_i;
  end
endmodule

// File: rtl/seep_page_buf.sv
module seep_page_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] slots [DEPTH];
  logic [DEPTH-1:0]  vld;

  always_ff @(posedge clk) begin
    if (we) slots[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (we) vld[widx] <= 1'b1;
  end

  always_comb begin
    rdata  = slots[ridx];
    rvalid = vld[ridx];
  end
endmodule

// File: rtl/seep_commit.sv
module seep_commit #(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 50000,
  parameter int IDX_W        = $clog2(PAGE_BYTES),
  parameter int PAGE_W       = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [PAGE_W-1:0] page_in,
  output logic              busy,
  output logic [IDX_W-1:0]  buf_idx,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0]  timer;
  logic [IDX_W-1:0]  idx;
  logic [PAGE_W-1:0] page;
  logic              scanning;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      timer    <= '0;
      idx      <= '0;
      page     <= '0;
      scanning <= 1'b0;
    end else if (go && !busy) begin
      busy     <= 1'b1;
      timer    <= CNT_W'(WRITE_CYCLES - 1);
      idx      <= '0;
      page     <= page_in;
      scanning <= 1'b1;
    end else if (busy) begin
      if (scanning) begin
        idx <= idx + 1'b1;
        if (idx == IDX_W'(PAGE_BYTES - 1)) scanning <= 1'b0;
      end
      if (timer == '0) busy <= 1'b0;
      else timer <= timer - 1'b1;
    end
  end

  always_comb begin
    buf_idx   = idx;
    mem_we    = scanning & buf_valid;
    mem_waddr = {page, idx};
    mem_wdata = buf_data;
  end

  assert_store_in_commit_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  assert_go_starts_busy_R8: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);
endmodule

// File: rtl/seep_array.sv
module seep_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int WORDS  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target #(
  parameter int ADDR_W       = 9,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe
);
  import seep_pkg::*;

  localparam int BYTE_W = 8;
  localparam int BLK_W  = ADDR_W - BYTE_W;
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - IDX_W;

  logic scl_rise, scl_fall, start_c, stop_c;

  bus_st_t           st;
  logic              ackph;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] rx;
  logic [BYTE_W-1:0] tx;
  logic [ADDR_W-1:0] ptr;
  logic [BLK_W-1:0]  blk;
  logic              mack;
  logic              wrote;
  logic              commit_go;
  logic              buf_clr, buf_we;
  logic [IDX_W-1:0]  buf_widx;
  logic [BYTE_W-1:0] buf_wdata;

  logic              busy;
  logic [IDX_W-1:0]  cm_idx;
  logic [BYTE_W-1:0] cm_data;
  logic              cm_valid;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] rd_q;

  seep_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  seep_page_buf #(.DATA_W(BYTE_W), .DEPTH(PAGE_BYTES)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .widx(buf_widx),
    .wdata(buf_wdata), .ridx(cm_idx), .rdata(cm_data), .rvalid(cm_valid)
  );

  seep_commit #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W), .PAGE_BYTES(PAGE_BYTES),
                .WRITE_CYCLES(WRITE_CYCLES)) u_commit (
    .clk(clk), .rst(rst), .go(commit_go), .page_in(ptr[ADDR_W-1:IDX_W]),
    .busy(busy), .buf_idx(cm_idx), .buf_data(cm_data), .buf_valid(cm_valid),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  seep_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rd_q)
  );

  // Bus state machine: bytes are shifted in on SCL rise; every drive change
  // happens on SCL fall. A current-address read uses the whole pointer.
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ackph     <= 1'b0;
      bitcnt    <= '0;
      rx        <= '0;
      tx        <= '0;
      ptr       <= '0;
      blk       <= '0;
      mack      <= 1'b0;
      wrote     <= 1'b0;
      sda_oe    <= 1'b0;
      commit_go <= 1'b0;
      buf_clr   <= 1'b0;
      buf_we    <= 1'b0;
      buf_widx  <= '0;
      buf_wdata <= '0;
    end else begin
      commit_go <= 1'b0;
      buf_clr   <= 1'b0;
      buf_we    <= 1'b0;
      if (start_c) begin
        st     <= ST_CTRL;
        ackph  <= 1'b0;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_c) begin
        commit_go <= (st == ST_WDATA) && wrote && !wp_i;
        st     <= ST_IDLE;
        ackph  <= 1'b0;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else begin
        unique case (st)
          ST_CTRL, ST_WADDR, ST_WDATA: begin
            if (ackph) begin
              if (scl_fall) begin
                ackph  <= 1'b0;
                sda_oe <= 1'b0;
              end
            end else if (scl_rise && bitcnt != 4'd8) begin
              rx     <= {rx[BYTE_W-2:0], sda_i};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == ST_CTRL) begin
                if (rx[7:4] == DEV_TAG && !busy) begin
                  sda_oe <= 1'b1;
                  ackph  <= 1'b1;
                  if (rx[0]) begin
                    st <= ST_READ;
                  end else begin
                    st      <= ST_WADDR;
                    blk     <= rx[BLK_W:1];
                    buf_clr <= 1'b1;
                  end
                end else begin
                  st <= ST_SKIP;
                end
              end else if (st == ST_WADDR) begin
                ptr    <= {blk, rx};
                sda_oe <= 1'b1;
                ackph  <= 1'b1;
                st     <= ST_WDATA;
              end else begin
                buf_we    <= 1'b1;
                buf_widx  <= ptr[IDX_W-1:0];
                buf_wdata <= rx;
                ptr       <= {ptr[ADDR_W-1:IDX_W], IDX_W'(ptr[IDX_W-1:0] + 1'b1)};
                wrote     <= 1'b1;
                sda_oe    <= 1'b1;
                ackph     <= 1'b1;
              end
            end
          end
          ST_READ: begin
            if (ackph) begin
              // The control-byte acknowledge slot samples the block's own low drive,
              // so the first byte is always loaded.
              if (scl_rise) begin
                mack <= ~sda_i;
              end else if (scl_fall) begin
                ackph <= 1'b0;
                if (mack) begin
                  tx     <= rd_q;
                  sda_oe <= ~rd_q[BYTE_W-1];
                  bitcnt <= 4'd1;
                  ptr    <= ptr + 1'b1;
                end else begin
                  sda_oe <= 1'b0;
                  st     <= ST_SKIP;
                end
              end
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ackph  <= 1'b1;
              end else begin
                sda_oe <= ~tx[BYTE_W-2];
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_drive_steady_scl_high_R2: assert property (@(posedge clk) disable iff (rst)
    scl_i |=> $stable(sda_oe));
  assert_no_ctrl_ack_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && $past(st) == ST_CTRL) |-> !$past(busy));
  assert_protect_blocks_commit_R9: assert property (@(posedge clk) disable iff (rst)
    commit_go |-> !$past(wp_i));
  assert_read_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_READ && !ackph && $past(st) == ST_READ && $past(ackph))
      |-> ptr == ADDR_W'($past(ptr) + 1'b1));
endmodule

// File: tb/serial_eeprom_target_bench.sv
module serial_eeprom_target_bench;
  localparam int WCYC = 200;
  localparam int H    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  serial_eeprom_target #(.WRITE_CYCLES(WCYC)) u_serial_eeprom_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .wp_i(wp), .sda_oe(sda_oe)
  );

  int  checks = 0;
  int  fails = 0;
  int  viol = 0;
  bit  may_drive = 1'b0;
  bit  done = 1'b0;
  int  mem_m [int];
  int  ptr_m = 0;
  int  dc_bits = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison: the line may be pulled only in slots the model expects.
  always @(posedge clk) begin
    #3;
    if (!rst && sda_oe && !may_drive) viol++;
  end

  task automatic step(input logic c, input logic d, input bit md);
    @(negedge clk);
    scl = c; sda_m = d; may_drive = md;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic hi_sample(output logic v);
    @(negedge clk);
    scl = 1'b1;
    repeat (2) @(negedge clk);
    v = sda_line;
    repeat (H - 3) @(negedge clk);
  endtask

  task automatic bstart;
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic bstop;
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
  endtask

  task automatic send_byte(input int b, input bit exp_ack, output bit ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      step(1'b0, b[i], 1'b0);
      step(1'b1, b[i], 1'b0);
    end
    step(1'b0, 1'b1, exp_ack);
    hi_sample(v);
    ack = ~v;
  endtask

  task automatic recv_byte(input bit master_ack, output int data);
    logic v;
    data = 0;
    for (int i = 7; i >= 0; i--) begin
      step(1'b0, 1'b1, 1'b1);
      hi_sample(v);
      data = data | (int'(v) << i);
    end
    step(1'b0, ~master_ack, 1'b0);
    step(1'b1, ~master_ack, 1'b0);
  endtask

  function automatic int ctrl_byte(input int rw, input int half);
    return (4'b1010 << 4) | ((dc_bits & 3) << 2) | ((half & 1) << 1) | (rw & 1);
  endfunction

  task automatic write_txn(input int addr, input int n, input int seed, input bit wait_done);
    bit ack;
    int bufv [16];
    bit bvld [16];
    int p;
    for (int k = 0; k < 16; k++) bvld[k] = 1'b0;
    bstart;
    send_byte(ctrl_byte(0, addr >> 8), 1'b1, ack);
    chk("R1 write control ack", ack, 1);
    send_byte(addr & 8'hFF, 1'b1, ack);
    chk("R3 word address ack", ack, 1);
    p = addr;
    for (int k = 0; k < n; k++) begin
      int d;
      d = (seed + k * 7) & 8'hFF;
      send_byte(d, 1'b1, ack);
      chk("R4 data ack", ack, 1);
      bufv[p & 15] = d;
      bvld[p & 15] = 1'b1;
      p = (p & ~15) | ((p + 1) & 15);
    end
    ptr_m = p;
    bstop;
    if (!wp && n > 0)
      for (int k = 0; k < 16; k++)
        if (bvld[k]) mem_m[(addr & ~15) | k] = bufv[k];
    if (wait_done) repeat (WCYC + 10) @(negedge clk);
  endtask

  task automatic read_seq(input int n, input bit set_addr, input int addr, input string req);
    bit ack;
    int d;
    if (set_addr) begin
      bstart;
      send_byte(ctrl_byte(0, addr >> 8), 1'b1, ack);
      chk("R5 dummy write control ack", ack, 1);
      send_byte(addr & 8'hFF, 1'b1, ack);
      chk("R3 dummy write address ack", ack, 1);
      ptr_m = addr;
    end
    bstart;
    send_byte(ctrl_byte(1, 0), 1'b1, ack);
    chk("R1 read control ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk(req, d, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) & 12'h1FF;
    end
    bstop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    int d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset sda_oe", sda_oe, 0);

    // R10: pointer starts at 0x000 - fill 0x000 first via address, then check wrap stream
    write_txn(12'h1FE, 2, 8'h31, 1'b1);
    write_txn(12'h000, 2, 8'h51, 1'b1);
    read_seq(4, 1'b1, 12'h1FE, "R7 sequential read across 0x1FF wrap");

    // R4 overwrite beyond 16 bytes, R6 current-address read after write
    write_txn(12'h150, 18, 8'h10, 1'b1);
    chk("R6 pointer after page write", ptr_m, 12'h152);
    read_seq(1, 1'b0, 0, "R6 current-address read after write");
    read_seq(16, 1'b1, 12'h150, "R4 page contents with overwrite");

    // R4 wrap inside the page
    write_txn(12'h12E, 4, 8'h90, 1'b1);
    read_seq(2, 1'b1, 12'h120, "R4 wrapped bytes at page start");
    read_seq(2, 1'b1, 12'h12E, "R4 bytes at page end");

    // R1 don't-care bits in control byte, current read continues at pointer
    dc_bits = 3;
    read_seq(1, 1'b0, 0, "R1 don't-care bits accepted, R6 current read");
    dc_bits = 0;

    // R1 wrong device tag: no acknowledge, nothing driven afterwards
    bstart;
    send_byte(8'h91, 1'b0, ack);
    chk("R1 wrong tag not acknowledged", ack, 0);
    send_byte(8'h00, 1'b0, ack);
    chk("R1 no drive after wrong tag", ack, 0);
    bstop;

    // R8 acknowledge polling during commit
    write_txn(12'h0A0, 1, 8'h66, 1'b0);
    bstart;
    send_byte(ctrl_byte(0, 0), 1'b0, ack);
    chk("R8 control refused while busy", ack, 0);
    bstop;
    repeat (WCYC + 10) @(negedge clk);
    read_seq(1, 1'b1, 12'h0A0, "R8 data stored after commit");

    // R5 repeated start discards buffered data
    write_txn(12'h040, 2, 8'h11, 1'b1);
    bstart;
    send_byte(ctrl_byte(0, 0), 1'b1, ack);
    chk("R5 control ack", ack, 1);
    send_byte(8'h40, 1'b1, ack);
    chk("R3 address ack", ack, 1);
    send_byte(8'h77, 1'b1, ack);
    chk("R5 data ack before repeated start", ack, 1);
    ptr_m = 12'h041;
    read_seq(1, 1'b0, 0, "R5 read after repeated start");
    read_seq(1, 1'b1, 12'h040, "R5 discarded byte not stored");

    // R9 write protect: acknowledged, nothing stored, not busy
    wp = 1'b1;
    write_txn(12'h040, 1, 8'h99, 1'b0);
    read_seq(1, 1'b1, 12'h040, "R9 protected location unchanged");
    wp = 1'b0;

    // R7 NACK releases the line: per-clock drive window check covers it
    chk("R2 drive only in expected slots", viol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule